// File: doc/BRIEF.md
# Wrap-Stamped Descriptor Ring Tracker

The block owns a circular ring of descriptor slots and serves both of its sides. A producer pushes entries in slot order. Each stored entry carries the producer's 4-bit pass count and an 8-bit ring identifier next to the payload. The pass count is zero after reset and steps by one each time the producer wraps from the last slot back to slot 0. After 15 it rolls over to 0.

The consumer side never looks at the producer's position. It keeps its own pass count. It treats the slot under its read index as new only when the least significant bit of the stamp in that slot matches the least significant bit of its own count. New entries appear on a valid/ready output stream.

After reset every slot holds a stamp of 15. This is odd, while the consumer's first expectation is even, so no slot is taken as new before the producer writes it. A full flag keeps the producer from overwriting slots the consumer has not yet taken. A separate peek port reads any slot directly.

Top module: `ring_wrap_tracker`

## Requirements
- R1: After reset, wr_idx_o, wr_pass_o and rd_pass_o are 0 and new_valid_o is 0. Every slot read through the peek port has 15 in bits [31:28] and zero in all other bits.
- R2: A write is accepted when wr_valid_i is 1, wr_full_o is 0 and wr_ring_id_i is nonzero. An accepted write stores, at slot wr_idx_o, the pass count in bits [31:28], the ring identifier in bits [27:20] and the payload in bits [19:0]. wr_idx_o then advances by one. A peek of that slot returns the stored word from the next cycle on.
- R3: When the write at slot DEPTH-1 is accepted, wr_idx_o returns to 0 and wr_pass_o increments modulo 16, so 15 is followed by 0.
- R4: A write with wr_ring_id_i equal to 0 (the idle ring) changes no slot, wr_idx_o or wr_pass_o.
- R5: wr_full_o is 1 exactly when the write index equals the consumer index (new_idx_o) and bit 0 of wr_pass_o differs from bit 0 of rd_pass_o. A write presented while wr_full_o is 1 changes nothing.
- R6: new_valid_o is 1 exactly when bit 28 of the slot at new_idx_o equals bit 0 of rd_pass_o. While it is 1, new_entry_o is that slot's word.
- R7: A transfer happens when new_valid_o and new_ready_i are both 1. It advances new_idx_o by one. Moving from slot DEPTH-1 to 0 increments rd_pass_o modulo 16.
- R8: While new_valid_o is 1 and new_ready_i is 0, new_valid_o stays 1 and new_entry_o and new_idx_o hold their values into the next cycle.
- R9: An accepted write into the slot at new_idx_o, when wr_full_o was 0, makes new_valid_o 1 in the cycle after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_valid_i | input | 1 | Producer presents an entry |
| wr_ring_id_i | input | 8 | Ring identifier stamped into the entry, 0 = idle ring |
| wr_payload_i | input | PAY_W | Entry payload, stored in the low bits |
| wr_idx_o | output | IDX_W | Slot the next accepted write goes to |
| wr_pass_o | output | 4 | Producer pass count |
| wr_full_o | output | 1 | Producer would overrun unread entries |
| peek_idx_i | input | IDX_W | Slot selected for direct read |
| peek_entry_o | output | PAY_W+12 | Word stored at peek_idx_i, 0 when out of range |
| new_valid_o | output | 1 | Slot at new_idx_o holds a new entry |
| new_ready_i | input | 1 | Consumer takes the new entry |
| new_entry_o | output | PAY_W+12 | Word at the consumer slot |
| new_idx_o | output | IDX_W | Consumer slot index |
| rd_pass_o | output | 4 | Consumer expected pass count |

## Verification
A wrong stamp or an out-of-step pass count shows up at the ports within one pass of the ring. The consumer either stalls in front of an entry it should take, with new_valid_o low, or it replays a stale slot with new_valid_o high. In both cases the stream diverges from the bench's arithmetic model in the first cycle of the mismatch. A wrong full decision shows up within a cycle, either as an overwritten word on the peek port or as a write index that does not move. The peek port exposes the whole ring contents every cycle, so a corrupted field position or a missed clear is visible before the consumer reaches that slot.

// File: rtl/ring_tracker_pkg.sv
package ring_tracker_pkg;
  localparam int PASS_W = 4;
  localparam int RID_W  = 8;
  localparam int STAMP_W = PASS_W + RID_W;
  typedef logic [PASS_W-1:0] pass_t;
  typedef logic [RID_W-1:0]  rid_t;
  // cleared stamp: odd pass so first consumer expectation (even) never matches
  localparam pass_t CLR_PASS = '1;
endpackage

// File: rtl/ring_pass_ptr.sv
module ring_pass_ptr
  import ring_tracker_pkg::*;
#(
  parameter int DEPTH = 6,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  output logic [IDX_W-1:0] idx_o,
  output pass_t            pass_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_o  <= '0;
      pass_o <= '0;
    end else if (step_i) begin
      if (idx_o == LAST) begin
        idx_o  <= '0;
        pass_o <= pass_o + pass_t'(1);
      end else begin
        idx_o <= idx_o + IDX_W'(1);
      end
    end
  end
endmodule

// File: rtl/ring_store.sv
module ring_store
  import ring_tracker_pkg::*;
#(
  parameter int DEPTH   = 6,
  parameter int ENTRY_W = 32,
  localparam int IDX_W  = $clog2(DEPTH)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [IDX_W-1:0]   waddr_i,
  input  logic [ENTRY_W-1:0] wdata_i,
  input  logic [IDX_W-1:0]   raddr_a_i,
  output logic [ENTRY_W-1:0] rdata_a_o,
  input  logic [IDX_W-1:0]   raddr_b_i,
  output logic [ENTRY_W-1:0] rdata_b_o
);
  localparam logic [ENTRY_W-1:0] CLR_WORD = {CLR_PASS, {(ENTRY_W-PASS_W){1'b0}}};

  logic [ENTRY_W-1:0] slot_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  slot_q[g] <= CLR_WORD;
      else if (we_i && waddr_i == IDX_W'(g))        slot_q[g] <= wdata_i;
    end
  end

  always_comb begin
    rdata_a_o = '0;
    rdata_b_o = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (raddr_a_i == IDX_W'(i)) rdata_a_o = slot_q[i];
      if (raddr_b_i == IDX_W'(i)) rdata_b_o = slot_q[i];
    end
  end
endmodule

// File: rtl/ring_wrap_tracker.sv
module ring_wrap_tracker
  import ring_tracker_pkg::*;
#(
  parameter int DEPTH = 6,
  parameter int PAY_W = 20,
  localparam int IDX_W   = $clog2(DEPTH),
  localparam int ENTRY_W = PAY_W + STAMP_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_valid_i,
  input  logic [RID_W-1:0]   wr_ring_id_i,
  input  logic [PAY_W-1:0]   wr_payload_i,
  output logic [IDX_W-1:0]   wr_idx_o,
  output logic [PASS_W-1:0]  wr_pass_o,
  output logic               wr_full_o,
  input  logic [IDX_W-1:0]   peek_idx_i,
  output logic [ENTRY_W-1:0] peek_entry_o,
  output logic               new_valid_o,
  input  logic               new_ready_i,
  output logic [ENTRY_W-1:0] new_entry_o,
  output logic [IDX_W-1:0]   new_idx_o,
  output logic [PASS_W-1:0]  rd_pass_o
);
  localparam int STAMP_LSB = ENTRY_W - PASS_W;

  logic push, pop;
  logic [ENTRY_W-1:0] wdata;

  // producer one pass ahead and on the consumer's slot: next write would clobber
  assign wr_full_o = (wr_idx_o == new_idx_o) && (wr_pass_o[0] != rd_pass_o[0]);
  assign push      = wr_valid_i && !wr_full_o && (wr_ring_id_i != '0);
  assign wdata     = {wr_pass_o, wr_ring_id_i, wr_payload_i};

  assign new_valid_o = (new_entry_o[STAMP_LSB] == rd_pass_o[0]);
  assign pop         = new_valid_o && new_ready_i;

  ring_pass_ptr #(.DEPTH(DEPTH)) u_wr_ptr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (push),
    .idx_o  (wr_idx_o),
    .pass_o (wr_pass_o)
  );

  ring_pass_ptr #(.DEPTH(DEPTH)) u_rd_ptr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (pop),
    .idx_o  (new_idx_o),
    .pass_o (rd_pass_o)
  );

  ring_store #(.DEPTH(DEPTH), .ENTRY_W(ENTRY_W)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (push),
    .waddr_i   (wr_idx_o),
    .wdata_i   (wdata),
    .raddr_a_i (new_idx_o),
    .rdata_a_o (new_entry_o),
    .raddr_b_i (peek_idx_i),
    .rdata_b_o (peek_entry_o)
  );
endmodule

// File: rtl/ring_wrap_tracker_chk.sv
module ring_wrap_tracker_chk #(
  parameter int DEPTH = 6,
  parameter int IDX_W = 3,
  parameter int ENTRY_W = 32
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               wr_valid_i,
  input logic [7:0]         wr_ring_id_i,
  input logic [IDX_W-1:0]   wr_idx_o,
  input logic [3:0]         wr_pass_o,
  input logic               wr_full_o,
  input logic               new_valid_o,
  input logic               new_ready_i,
  input logic [ENTRY_W-1:0] new_entry_o,
  input logic [IDX_W-1:0]   new_idx_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  // R4
  idle_ring_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && wr_ring_id_i == 8'd0) |=> ($stable(wr_idx_o) && $stable(wr_pass_o)));

  // R5
  full_blocks_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_full_o |=> $stable(wr_idx_o));

  // R5
  full_implies_pending_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_full_o |-> new_valid_o);

  // R3
  pass_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_idx_o == LAST && wr_valid_i && !wr_full_o && wr_ring_id_i != 8'd0)
      |=> (wr_idx_o == '0 && wr_pass_o == $past(wr_pass_o) + 4'd1));

  // R7
  pop_advance_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (new_valid_o && new_ready_i) |=> (new_idx_o != $past(new_idx_o)));

  // R8
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (new_valid_o && !new_ready_i)
      |=> (new_valid_o && $stable(new_entry_o) && $stable(new_idx_o)));
endmodule

bind ring_wrap_tracker ring_wrap_tracker_chk #(
  .DEPTH(DEPTH), .IDX_W(IDX_W), .ENTRY_W(ENTRY_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wr_valid_i   (wr_valid_i),
  .wr_ring_id_i (wr_ring_id_i),
  .wr_idx_o     (wr_idx_o),
  .wr_pass_o    (wr_pass_o),
  .wr_full_o    (wr_full_o),
  .new_valid_o  (new_valid_o),
  .new_ready_i  (new_ready_i),
  .new_entry_o  (new_entry_o),
  .new_idx_o    (new_idx_o)
);

// File: tb/ring_wrap_tracker_test.sv
`timescale 1ns/1ps
module ring_wrap_tracker_test;
  localparam int DEPTH = 6;
  localparam int PAY_W = 20;
  localparam int IDX_W = $clog2(DEPTH);
  localparam int EW    = PAY_W + 12;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic wr_valid_i = 1'b0;
  logic [7:0] wr_ring_id_i = '0;
  logic [PAY_W-1:0] wr_payload_i = '0;
  logic [IDX_W-1:0] wr_idx_o;
  logic [3:0] wr_pass_o;
  logic wr_full_o;
  logic [IDX_W-1:0] peek_idx_i = '0;
  logic [EW-1:0] peek_entry_o;
  logic new_valid_o;
  logic new_ready_i = 1'b0;
  logic [EW-1:0] new_entry_o;
  logic [IDX_W-1:0] new_idx_o;
  logic [3:0] rd_pass_o;

  always #2.5 clk_i = ~clk_i;

  ring_wrap_tracker #(.DEPTH(DEPTH), .PAY_W(PAY_W)) uut (.*);

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [EW-1:0] mem_m [DEPTH];
  int wp = 0, rp = 0;
  logic [3:0] wpass = '0, rpass = '0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cycle(input logic v, input logic [7:0] id, input logic [PAY_W-1:0] pl,
                       input logic rdy, input int pk);
    logic exp_full, exp_nv, acc, pop;
    wr_valid_i = v; wr_ring_id_i = id; wr_payload_i = pl;
    new_ready_i = rdy; peek_idx_i = IDX_W'(pk);
    #1;
    exp_full = (wp == rp) && (wpass[0] != rpass[0]);
    exp_nv   = (mem_m[rp][EW-4] == rpass[0]);
    chk("R5 wr_full", 32'(wr_full_o), 32'(exp_full));
    chk("R2/R4 wr_idx", 32'(wr_idx_o), 32'(wp));
    chk("R3 wr_pass", 32'(wr_pass_o), 32'(wpass));
    chk("R6/R9 new_valid", 32'(new_valid_o), 32'(exp_nv));
    chk("R7 new_idx", 32'(new_idx_o), 32'(rp));
    chk("R7 rd_pass", 32'(rd_pass_o), 32'(rpass));
    if (exp_nv) chk("R6/R8 new_entry", 32'(new_entry_o), 32'(mem_m[rp]));
    chk("R2 peek", 32'(peek_entry_o), 32'(mem_m[pk]));
    @(posedge clk_i);
    acc = v && !exp_full && (id != 8'd0);
    pop = exp_nv && rdy;
    if (acc) begin
      mem_m[wp] = {wpass, id, pl};
      if (wp == DEPTH - 1) begin wp = 0; wpass = wpass + 4'd1; end
      else wp = wp + 1;
    end
    if (pop) begin
      if (rp == DEPTH - 1) begin rp = 0; rpass = rpass + 4'd1; end
      else rp = rp + 1;
    end
    @(negedge clk_i);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) mem_m[i] = {4'hF, {(EW-4){1'b0}}};
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    // R1 reset state
    chk("R1 wr_idx", 32'(wr_idx_o), 0);
    chk("R1 wr_pass", 32'(wr_pass_o), 0);
    chk("R1 rd_pass", 32'(rd_pass_o), 0);
    chk("R1 new_valid", 32'(new_valid_o), 0);
    for (int i = 0; i < DEPTH; i++) begin
      peek_idx_i = IDX_W'(i);
      #0.1;
      chk("R1 cleared slot", 32'(peek_entry_o), 32'({4'hF, {(EW-4){1'b0}}}));
    end
    @(negedge clk_i);
    for (int c = 0; c < 1200; c++) begin
      logic v, rdy;
      logic [7:0] id;
      if (c < 20) begin
        v = 1'b1; id = 8'(8'h11 + c); rdy = 1'b0;          // fill, then R5 writes while full
      end else if (c < 40) begin
        v = 1'b0; id = 8'h01; rdy = 1'b1;                  // drain
      end else if (c < 60) begin
        v = 1'b1; id = 8'h00; rdy = (c % 3 == 0);          // R4 idle ring writes
      end else begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        v   = lfsr[0] | lfsr[1];
        rdy = (c < 600) ? (lfsr[3] & lfsr[4]) : (lfsr[3] | lfsr[4]);
        id  = (lfsr[7:5] == 3'd0) ? 8'h00 : {lfsr[15:9], 1'b1};
      end
      cycle(v, id, PAY_W'({lfsr, c[3:0]}), rdy, c % DEPTH);
    end
    // final drain of whatever remains (R7 wrap)
    for (int c = 0; c < 3 * DEPTH; c++) cycle(1'b0, 8'h00, '0, 1'b1, c % DEPTH);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule